// File: doc/BRIEF.md
# Wait-State Bus Master

This block is the master side of a simple 16-bit-address parallel bus. It runs single read and write cycles through the clock states T1, T2, optional wait periods, and T3. The core clock `clk_i` runs at twice the bus rate. An internal phase toggle splits each bus period into a high half and a low half. The block drives the bus clock, and it places address, strobes and write data on chosen half-period boundaries.

A client raises `req_i` with an address, a direction and write data. It holds the request until the block accepts it. While the block is idle, `ready_o` is high during the second half of each bus period. A request accepted at that edge starts T1 on the next edge.

The number of wait periods is the larger of two values:
- a fixed count taken from `cfg_wait_i` when the request is accepted;
- the number of consecutive bus periods during which the slave's `wait_i` is sampled high.

Read data is returned on `rdata_o`, marked by a one-cycle `done_o` pulse.

Top module: `wait_bus_master`

## Requirements
- R1: While `rst_ni` is low and right after its release, `rd_n_o` and `wr_n_o` are high, and `bus_doe_o` and `done_o` are low.
- R2: A request is taken only on a rising `clk_i` edge where `req_i` and `ready_o` are both high. `ready_o` is high only while idle, in the low half of a bus period, so it is high on alternate `clk_i` cycles. A request raised and dropped during a cycle in progress starts nothing and does not alter `addr_o`.
- R3: `addr_o` carries the accepted address from the first half after acceptance (T1 high), with both strobes still high. It stays stable for as long as any strobe is low.
- R4: The active strobe goes low in the T1 low half and stays low through the T3 high half. For N wait periods it is low for exactly 4+2N consecutive `clk_i` cycles.
- R5: `cfg_wait_i` (0..7), sampled at acceptance, gives the fixed number of wait periods inserted between T2 and T3.
- R6: `wait_i` is sampled at the end of T2 and at the end of each wait period. The cycle moves to T3 only when the fixed count is used up and `wait_i` is sampled low. As a result, N = max(fixed count, number of consecutive high samples).
- R7: For reads, `bus_din_i` is captured at the end of the T3 high half. It appears on `rdata_o` while `done_o` is high and is held afterwards until the next capture.
- R8: For writes (`req_we_i`=1), `wr_n_o` takes the place of `rd_n_o`, which stays high. `bus_doe_o` rises together with `wr_n_o` falling, with `bus_dout_o` equal to the write data. It falls one half-period after `wr_n_o` rises.
- R9: `done_o` is high for exactly one `clk_i` cycle per transfer: the T3 low half, where the strobe has just gone high.
- R10: `bus_clk_o` toggles every `clk_i` cycle and is high in the first half of each bus period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, twice the bus rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wait_i | input | 3 | Fixed wait periods, 0..7 |
| req_i | input | 1 | Transfer request, held until accepted |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Transfer address |
| req_wdata_i | input | 8 | Write data |
| ready_o | output | 1 | A request is accepted at the coming edge |
| done_o | output | 1 | End-of-transfer pulse |
| rdata_o | output | 8 | Captured read data |
| bus_clk_o | output | 1 | Bus clock |
| addr_o | output | 16 | Bus address |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| bus_dout_o | output | 8 | Bus write data |
| bus_doe_o | output | 1 | Write data output enable |
| bus_din_i | input | 8 | Bus read data |
| wait_i | input | 1 | Slave stretch request, active high |

## Verification
All timing is counted in `clk_i` cycles (half bus periods) from the accepting edge:
- address in cycle 1 (T1 high);
- strobe low in cycles 2 to 5+2N;
- `done_o` and the strobe rising in cycle 6+2N;
- write enable dropping in cycle 7+2N.

The bench samples on falling `clk_i` edges. It counts strobe-low halves, and its expected N is computed as max(fixed, stretch). It places valid read data on `bus_din_i` only during the single half that ends in the capture edge, and drives garbage everywhere else. It drives `wait_i` per half from that same count, so each high sample lands on a period end.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_T1,
    S_T2,
    S_TW,
    S_T3
  } bus_state_e;
endpackage

// File: rtl/wbm_phase.sv
module wbm_phase (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ph_o     // 0: high half, 1: low half of the bus period
);
  logic ph_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end
  assign ph_o = ph_q;
endmodule

// File: rtl/wbm_wait_ctr.sv
module wbm_wait_ctr #(
  parameter int unsigned CntW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [CntW-1:0] val_i,
  input  logic            dec_i,
  output logic            zero_o,
  output logic            last_o
);
  localparam logic [CntW-1:0] One = CntW'(1);
  logic [CntW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - One;
  end
  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q <= One);
endmodule

// File: rtl/wbm_datapath.sv
module wbm_datapath #(
  parameter int unsigned AddrW = 16,
  parameter int unsigned DataW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [AddrW-1:0] addr_i,
  input  logic [DataW-1:0] wdata_i,
  input  logic             we_i,
  input  logic             cap_i,
  input  logic [DataW-1:0] din_i,
  output logic [AddrW-1:0] addr_o,
  output logic [DataW-1:0] wdata_o,
  output logic             we_o,
  output logic [DataW-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      we_o    <= 1'b0;
    end else if (load_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      we_o    <= we_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (cap_i) rdata_o <= din_i;
  end
endmodule

// File: rtl/wait_bus_master.sv
module wait_bus_master
  import wbm_pkg::*;
#(
  parameter int unsigned AddrW = 16,
  parameter int unsigned DataW = 8,
  parameter int unsigned WaitW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WaitW-1:0] cfg_wait_i,
  input  logic             req_i,
  input  logic             req_we_i,
  input  logic [AddrW-1:0] req_addr_i,
  input  logic [DataW-1:0] req_wdata_i,
  output logic             ready_o,
  output logic             done_o,
  output logic [DataW-1:0] rdata_o,
  output logic             bus_clk_o,
  output logic [AddrW-1:0] addr_o,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic [DataW-1:0] bus_dout_o,
  output logic             bus_doe_o,
  input  logic [DataW-1:0] bus_din_i,
  input  logic             wait_i
);
  bus_state_e state_q, state_d;
  logic ph, accept, cnt_zero, cnt_last, dec, we_q, strb_on, cap;

  wbm_phase u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ph_o  (ph)
  );

  assign ready_o = (state_q == S_IDLE) && ph;
  assign accept  = ready_o && req_i;
  assign dec     = (state_q == S_TW) && ph;

  wbm_wait_ctr #(.CntW(WaitW)) u_wait_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .val_i (cfg_wait_i),
    .dec_i (dec),
    .zero_o(cnt_zero),
    .last_o(cnt_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (accept) state_d = S_T1;
      S_T1:   if (ph) state_d = S_T2;
      S_T2:   if (ph) state_d = (!cnt_zero || wait_i) ? S_TW : S_T3;
      S_TW:   if (ph && cnt_last && !wait_i) state_d = S_T3;
      S_T3:   if (ph) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  // capture at the end of the T3 high half
  assign cap = (state_q == S_T3) && !ph;

  wbm_datapath #(.AddrW(AddrW), .DataW(DataW)) u_datapath (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .addr_i (req_addr_i),
    .wdata_i(req_wdata_i),
    .we_i   (req_we_i),
    .cap_i  (cap),
    .din_i  (bus_din_i),
    .addr_o (addr_o),
    .wdata_o(bus_dout_o),
    .we_o   (we_q),
    .rdata_o(rdata_o)
  );

  // strobe window: T1 low .. T3 high
  assign strb_on = ((state_q == S_T1) && ph) || (state_q == S_T2) ||
                   (state_q == S_TW) || ((state_q == S_T3) && !ph);
  assign rd_n_o    = !(strb_on && !we_q);
  assign wr_n_o    = !(strb_on && we_q);
  assign bus_doe_o = we_q && (strb_on || ((state_q == S_T3) && ph));
  assign done_o    = (state_q == S_T3) && ph;
  assign bus_clk_o = !ph;
endmodule

// File: rtl/wbm_checker.sv
module wbm_checker #(
  parameter int unsigned AddrW = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ready_o,
  input logic             done_o,
  input logic             bus_clk_o,
  input logic [AddrW-1:0] addr_o,
  input logic             rd_n_o,
  input logic             wr_n_o,
  input logic             bus_doe_o,
  input logic             wait_i
);
  logic strb_low;
  assign strb_low = !rd_n_o || !wr_n_o;

  p_strobe_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));

  p_ready_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (rd_n_o && wr_n_o && !bus_doe_o && !done_o));

  p_addr_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_low |=> $stable(addr_o));

  p_wait_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_low && !bus_clk_o && wait_i) |=> strb_low);

  p_done_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($rose(rd_n_o) || $rose(wr_n_o)));

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_doe_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_n_o) |=> !bus_doe_o);

  p_doe_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |-> bus_doe_o);
endmodule

bind wait_bus_master wbm_checker #(.AddrW(AddrW)) u_wbm_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ready_o  (ready_o),
  .done_o   (done_o),
  .bus_clk_o(bus_clk_o),
  .addr_o   (addr_o),
  .rd_n_o   (rd_n_o),
  .wr_n_o   (wr_n_o),
  .bus_doe_o(bus_doe_o),
  .wait_i   (wait_i)
);

// File: tb/wait_bus_master_bench.sv
module wait_bus_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_wait = '0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, bus_din = '0;
  logic        wait_in = 1'b0;
  logic        ready, done, bus_clk, rd_n, wr_n, doe;
  logic [7:0]  rdata, dout;
  logic [15:0] addr;
  int n_checks = 0, n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wait_bus_master u_wait_bus_master (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wait_i(cfg_wait), .req_i(req),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .ready_o(ready), .done_o(done), .rdata_o(rdata), .bus_clk_o(bus_clk),
    .addr_o(addr), .rd_n_o(rd_n), .wr_n_o(wr_n), .bus_dout_o(dout),
    .bus_doe_o(doe), .bus_din_i(bus_din), .wait_i(wait_in)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk(rd_n && wr_n, "R1 strobes in reset", {rd_n, wr_n}, 2'b11);
    chk(!doe && !done, "R1 doe/done in reset", {doe, done}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_n && wr_n && !doe && !done, "R1 after release", {rd_n, wr_n, doe, done}, 4'b1100);
    begin
      int rdy = 0, tog = 0;
      logic prev = bus_clk;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        rdy += int'(ready);
        if (bus_clk != prev) tog++;
        if (ready) chk(!bus_clk, "R10 ready in low half", bus_clk, 0);
        prev = bus_clk;
      end
      chk(rdy == 4, "R2 ready alternates when idle", rdy, 4);
      chk(tog == 8, "R10 bus clock toggles each cycle", tog, 8);
    end
  endtask

  // one transfer; n = expected wait periods
  task automatic xfer(input bit we, input logic [15:0] a, input logic [7:0] d,
                      input logic [2:0] cfg, input int k, input string tag);
    int n = (int'(cfg) > k) ? int'(cfg) : k;
    int h = 0, oe = 0;
    bit other_low = 1'b0;
    @(negedge clk);
    cfg_wait = cfg; req_we = we; req_addr = a; req_wdata = d; req = 1'b1;
    bus_din = ~d;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req = 1'b0; cfg_wait = '0; req_addr = ~a;
    chk(addr == a, {tag, " R3 address in T1 high"}, addr, a);
    chk(rd_n && wr_n, {tag, " R3 strobes high in T1 high"}, {rd_n, wr_n}, 2'b11);
    for (int i = 0; i < 60 && !done; i++) begin
      @(negedge clk);
      if (!done) begin
        if (we ? !wr_n : !rd_n) h++;
        if (we ? !rd_n : !wr_n) other_low = 1'b1;
        if (doe) oe++;
        if (we && !wr_n && dout != d) chk(0, {tag, " R8 write data"}, dout, d);
        if (addr != a) chk(0, {tag, " R3 address stable"}, addr, a);
        bus_din = (h == 4 + 2*n) ? d : ~d;
        wait_in = (h < 2*k + 2) && (k > 0);
      end
    end
    wait_in = 1'b0;
    chk(done, {tag, " R9 done seen"}, done, 1);
    chk(h == 4 + 2*n, {tag, " R4 R5 R6 strobe low halves"}, h, 4 + 2*n);
    chk(!other_low, {tag, " R8 unused strobe stays high"}, other_low, 0);
    chk(rd_n && wr_n, {tag, " R9 strobe high at done"}, {rd_n, wr_n}, 2'b11);
    if (we) begin
      chk(doe && dout == d, {tag, " R8 data held past strobe"}, {doe, dout}, {1'b1, d});
      chk(oe == 4 + 2*n, {tag, " R8 enable with strobe"}, oe, 4 + 2*n);
    end else begin
      chk(!doe, {tag, " R8 no enable on read"}, doe, 0);
      chk(rdata == d, {tag, " R7 read data at done"}, rdata, d);
    end
    @(negedge clk);
    chk(!done, {tag, " R9 done single cycle"}, done, 0);
    chk(!doe, {tag, " R8 enable released"}, doe, 0);
    if (!we) chk(rdata == d, {tag, " R7 read data held"}, rdata, d);
  endtask

  task automatic test_busy;
    @(negedge clk);
    cfg_wait = 3'd2; req_we = 1'b0; req_addr = 16'h1234; req = 1'b1;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    req_addr = 16'hBEEF; req_we = 1'b1; req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!ready, "R2 not ready while busy", ready, 0);
    end
    req = 1'b0;
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    chk(addr == 16'h1234, "R2 address unchanged by busy request", addr, 16'h1234);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!rd_n || !wr_n || addr != 16'h1234)
        chk(0, "R2 busy request started nothing", {rd_n, wr_n, addr}, {2'b11, 16'h1234});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    xfer(1'b0, 16'h0001, 8'hA5, 3'd0, 0, "rd w0");
    xfer(1'b0, 16'hFFFF, 8'h3C, 3'd3, 0, "rd w3");
    xfer(1'b1, 16'h8000, 8'h5A, 3'd2, 0, "wr w2");
    xfer(1'b0, 16'h00F0, 8'h81, 3'd0, 3, "rd stretch3");
    xfer(1'b1, 16'h7777, 8'hC3, 3'd4, 2, "wr w4 stretch2");
    xfer(1'b0, 16'h4242, 8'h18, 3'd1, 3, "rd w1 stretch3");
    xfer(1'b0, 16'hABCD, 8'hE7, 3'd7, 0, "rd w7");
    test_busy();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule